// File: doc/BRIEF.md
# Queued Host Access to Per-Engine Transmit and Receive Buffers

This block holds the word buffers between a host bus and four independent sequencing engines. Each engine has a transmit queue filled by the host and drained by the engine, and a receive queue filled by the engine and drained by the host. Each queue is 32 bits wide and four words deep. A host access is a single-cycle register write or read on a small word-addressed map. Read data comes back combinationally in the same cycle as the read strobe. Pushes and pops take effect at the next clock edge.

Pushing into a full transmit queue or popping from an empty receive queue is dropped and does not touch the queue. Instead it sets a sticky error bit kept for that queue. The host clears that bit by writing a one to it. Status and occupancy words let the host see how far each queue is filled. For each engine, the receive storage can also be switched into an indexed mode, in which the host reads and writes its four slots like plain registers.

Top module: `fifo_host_access`

## Requirements
- R1: A host write to address 4+m pushes the written word into the transmit queue of engine m. The queue occupancy rises by one, and the engine sees the words on `smTxData[32m+31:32m]` in the order they were written. Each `smTxPop[m]` pulse removes the head word.
- R2: A host write to address 4+m while that transmit queue holds four words leaves the queue's occupancy and contents unchanged, and sets error bit m (overflow of transmit queue m).
- R3: A host read of address 8+m returns the oldest word of engine m's receive queue, which the engine filled with `smRxPush[m]` and `smRxData[32m+31:32m]`, and removes that word.
- R4: A host read of address 8+m while that receive queue is empty leaves the queue unchanged, and sets error bit 4+m (underflow of receive queue m). The returned data is unspecified.
- R5: The four transmit ports sit at consecutive addresses 4..7 and the four receive ports at 8..11. Each engine's queues are independent of the others.
- R6: The error bits read at address 1 are sticky. A write to address 1 clears exactly the bits written as one, and a zero bit leaves its flag as it is.
- R7: A read of address 0 returns the status word: bit m is transmit queue m full, bit 4+m transmit m empty, bit 8+m receive m full, bit 12+m receive m empty, and the upper bits are zero.
- R8: A read of address 2 returns the occupancy word: bits [8m+3:8m] hold the transmit level of engine m and bits [8m+7:8m+4] the receive level, each 0 to 4.
- R9: A push and a pop on the same non-empty, non-full queue in the same cycle both complete, and the level stays unchanged.
- R10: Address 3 holds the mode bits, two per engine: bit 2m is enable A and bit 2m+1 is enable B. When exactly one of the two is set for engine m, a write to address 16+4m+i stores into receive slot i, and a read of that address returns slot i.
- R11: When both enables, or neither, are set for engine m, reads of 16+4m+i return zero and writes there change no slot.
- R12: An engine pop of an empty transmit queue and an engine push into a full receive queue are ignored.
- R13: After reset, every queue is empty, all levels are zero and all error bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | 5 | Host word address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, same cycle |
| smTxPop | input | 4 | Per-engine transmit pop strobes |
| smTxData | output | 128 | Per-engine transmit head words |
| smRxPush | input | 4 | Per-engine receive push strobes |
| smRxData | input | 128 | Per-engine receive push words |

## Verification
Directed sequences first fill one transmit queue past its limit and read an empty receive queue. These show that dropped accesses leave occupancy alone, and that each raises only its own error bit. A zero write and a single-bit write to the error word then separate sticky retention from a clear-one-bit action. A long seeded random mix of host pushes, host pops, engine strobes and status reads is scored against a bench queue model. It catches ordering, cross-engine leakage and simultaneous push/pop counting, because engine strobes often collide with host accesses to the same queue. Last, the indexed receive mode is exercised under all four enable combinations, which separates the exclusive-or condition from a plain OR.

// File: rtl/fha_pkg.sv
package fha_pkg;
  localparam int NUM_SM = 4;
  localparam int DEPTH  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int SEL_W  = $clog2(NUM_SM);

  typedef struct packed {
    logic [NUM_SM-1:0] txPush;
    logic [NUM_SM-1:0] rxPop;
    logic [NUM_SM-1:0] rxDirWr;
    logic [PTR_W-1:0]  dirIdx;
    logic [DATA_W-1:0] wdata;
  } strobes_t;
endpackage

// File: rtl/fha_fifo.sv
module fha_fifo
  import fha_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  input  logic              dirWr,
  input  logic [PTR_W-1:0]  dirIdx,
  input  logic [DATA_W-1:0] dirData,
  output logic [DATA_W-1:0] head,
  output logic [DATA_W-1:0] dirRd,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (level == CNT_W'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];
  assign dirRd  = mem[dirIdx];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (dirWr)  mem[dirIdx] <= dirData;
    if (doPush) mem[wrPtr]  <= pushData;
  end
endmodule

// File: rtl/fha_datapath.sv
module fha_datapath
  import fha_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 strb,
  input  logic [NUM_SM-1:0]        smTxPop,
  input  logic [NUM_SM-1:0]        smRxPush,
  input  logic [NUM_SM*DATA_W-1:0] smRxData,
  output logic [NUM_SM*DATA_W-1:0] smTxData,
  output logic [NUM_SM*DATA_W-1:0] rxHead,
  output logic [NUM_SM*DATA_W-1:0] dirRdData,
  output logic [NUM_SM-1:0]        txFull,
  output logic [NUM_SM-1:0]        txEmpty,
  output logic [NUM_SM-1:0]        rxFull,
  output logic [NUM_SM-1:0]        rxEmpty,
  output logic [NUM_SM*CNT_W-1:0]  txLevel,
  output logic [NUM_SM*CNT_W-1:0]  rxLevel
);
  for (genvar m = 0; m < NUM_SM; m++) begin : g_sm
    logic [DATA_W-1:0] txDirUnused;
    fha_fifo i_tx (
      .clk(clk), .rstN(rstN),
      .push(strb.txPush[m]), .pushData(strb.wdata),
      .pop(smTxPop[m]),
      .dirWr(1'b0), .dirIdx(strb.dirIdx), .dirData(strb.wdata),
      .head(smTxData[m*DATA_W +: DATA_W]), .dirRd(txDirUnused),
      .full(txFull[m]), .empty(txEmpty[m]),
      .level(txLevel[m*CNT_W +: CNT_W])
    );
    fha_fifo i_rx (
      .clk(clk), .rstN(rstN),
      .push(smRxPush[m]), .pushData(smRxData[m*DATA_W +: DATA_W]),
      .pop(strb.rxPop[m]),
      .dirWr(strb.rxDirWr[m]), .dirIdx(strb.dirIdx), .dirData(strb.wdata),
      .head(rxHead[m*DATA_W +: DATA_W]), .dirRd(dirRdData[m*DATA_W +: DATA_W]),
      .full(rxFull[m]), .empty(rxEmpty[m]),
      .level(rxLevel[m*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/fha_ctrl.sv
module fha_ctrl
  import fha_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostWrEn,
  input  logic                     hostRdEn,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [DATA_W-1:0]        hostWdata,
  input  logic [NUM_SM-1:0]        txFull,
  input  logic [NUM_SM-1:0]        txEmpty,
  input  logic [NUM_SM-1:0]        rxFull,
  input  logic [NUM_SM-1:0]        rxEmpty,
  input  logic [NUM_SM*CNT_W-1:0]  txLevel,
  input  logic [NUM_SM*CNT_W-1:0]  rxLevel,
  input  logic [NUM_SM*DATA_W-1:0] rxHead,
  input  logic [NUM_SM*DATA_W-1:0] dirRdData,
  output strobes_t                 strb,
  output logic [2*NUM_SM-1:0]      errFlags,
  output logic [DATA_W-1:0]        hostRdata
);
  localparam logic [ADDR_W-1:0] A_STATUS = 'd0;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 'd1;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 'd2;
  localparam logic [ADDR_W-1:0] A_MODE   = 'd3;

  logic [2*NUM_SM-1:0] joinCfg;
  logic [NUM_SM-1:0]   dirMode, ovfSet, undSet;
  logic [SEL_W-1:0]    sel, dirSm;
  logic isTx, isRx, isDir;
  logic [DATA_W-1:0]   levelWord;

  assign sel   = hostAddr[SEL_W-1:0];
  assign dirSm = hostAddr[PTR_W +: SEL_W];
  assign isTx  = (hostAddr[ADDR_W-1:2] == 3'b001);
  assign isRx  = (hostAddr[ADDR_W-1:2] == 3'b010);
  assign isDir = hostAddr[ADDR_W-1];

  always_comb begin
    strb        = '0;
    strb.dirIdx = hostAddr[PTR_W-1:0];
    strb.wdata  = hostWdata;
    ovfSet      = '0;
    undSet      = '0;
    levelWord   = '0;
    for (int m = 0; m < NUM_SM; m++) begin
      dirMode[m] = joinCfg[2*m] ^ joinCfg[2*m+1];
      if (hostWrEn && isTx && sel == SEL_W'(m)) begin
        strb.txPush[m] = !txFull[m];
        ovfSet[m]      = txFull[m];
      end
      if (hostRdEn && isRx && sel == SEL_W'(m)) begin
        strb.rxPop[m] = !rxEmpty[m];
        undSet[m]     = rxEmpty[m];
      end
      strb.rxDirWr[m] = hostWrEn && isDir && dirSm == SEL_W'(m) && dirMode[m];
      levelWord[8*m +: 4]     = 4'(txLevel[m*CNT_W +: CNT_W]);
      levelWord[8*m + 4 +: 4] = 4'(rxLevel[m*CNT_W +: CNT_W]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlags <= '0;
      joinCfg  <= '0;
    end else begin
      errFlags <= (errFlags & ~((hostWrEn && hostAddr == A_FLAGS) ?
                   hostWdata[2*NUM_SM-1:0] : '0)) | {undSet, ovfSet};
      if (hostWrEn && hostAddr == A_MODE) joinCfg <= hostWdata[2*NUM_SM-1:0];
    end
  end

  always_comb begin
    hostRdata = '0;
    if (isDir) begin
      if (dirMode[dirSm]) hostRdata = dirRdData[dirSm*DATA_W +: DATA_W];
    end else if (isRx) begin
      hostRdata = rxHead[sel*DATA_W +: DATA_W];
    end else begin
      case (hostAddr)
        A_STATUS: hostRdata = DATA_W'({rxEmpty, rxFull, txEmpty, txFull});
        A_FLAGS:  hostRdata = DATA_W'(errFlags);
        A_LEVEL:  hostRdata = levelWord;
        A_MODE:   hostRdata = DATA_W'(joinCfg);
        default:  hostRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fifo_host_access.sv
module fifo_host_access
  import fha_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostWrEn,
  input  logic                     hostRdEn,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [DATA_W-1:0]        hostWdata,
  output logic [DATA_W-1:0]        hostRdata,
  input  logic [NUM_SM-1:0]        smTxPop,
  output logic [NUM_SM*DATA_W-1:0] smTxData,
  input  logic [NUM_SM-1:0]        smRxPush,
  input  logic [NUM_SM*DATA_W-1:0] smRxData
);
  strobes_t strb;
  logic [NUM_SM-1:0] txFull, txEmpty, rxFull, rxEmpty;
  logic [NUM_SM*CNT_W-1:0] txLevel, rxLevel;
  logic [NUM_SM*DATA_W-1:0] rxHead, dirRdData;
  logic [2*NUM_SM-1:0] errFlags;

  fha_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxHead(rxHead), .dirRdData(dirRdData),
    .strb(strb), .errFlags(errFlags), .hostRdata(hostRdata)
  );

  fha_datapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .smTxPop(smTxPop), .smRxPush(smRxPush), .smRxData(smRxData),
    .smTxData(smTxData), .rxHead(rxHead), .dirRdData(dirRdData),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txLevel(txLevel), .rxLevel(rxLevel)
  );
endmodule

// File: rtl/fha_checker.sv
module fha_checker
  import fha_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    hostWrEn,
  input logic                    hostRdEn,
  input logic [ADDR_W-1:0]       hostAddr,
  input logic [DATA_W-1:0]       hostWdata,
  input logic [NUM_SM-1:0]       smTxPop,
  input logic [NUM_SM-1:0]       smRxPush,
  input logic [NUM_SM-1:0]       txFull,
  input logic [NUM_SM-1:0]       txEmpty,
  input logic [NUM_SM-1:0]       rxEmpty,
  input logic [NUM_SM*CNT_W-1:0] txLevel,
  input logic [NUM_SM*CNT_W-1:0] rxLevel,
  input logic [2*NUM_SM-1:0]     errFlags
);
  for (genvar m = 0; m < NUM_SM; m++) begin : g_sm
    logic txWr, rxRd;
    assign txWr = hostWrEn && hostAddr == ADDR_W'(4 + m);
    assign rxRd = hostRdEn && hostAddr == ADDR_W'(8 + m);

    AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rstN)
      txWr && !txFull[m] && !smTxPop[m] |=> txLevel[m*CNT_W +: CNT_W] == $past(txLevel[m*CNT_W +: CNT_W]) + 1'b1); // R1
    AST_FULL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
      txWr && txFull[m] && !smTxPop[m] |=> $stable(txLevel[m*CNT_W +: CNT_W])); // R2
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
      txWr && txFull[m] |=> errFlags[m]); // R2
    AST_EMPTY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
      rxRd && rxEmpty[m] && !smRxPush[m] |=> $stable(rxLevel[m*CNT_W +: CNT_W])); // R4
    AST_UND_SET: assert property (@(posedge clk) disable iff (!rstN)
      rxRd && rxEmpty[m] |=> errFlags[NUM_SM + m]); // R4
    AST_LEVEL_SAME: assert property (@(posedge clk) disable iff (!rstN)
      txWr && !txFull[m] && !txEmpty[m] && smTxPop[m] |=> $stable(txLevel[m*CNT_W +: CNT_W])); // R9
  end

  for (genvar b = 0; b < 2*NUM_SM; b++) begin : g_flag
    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      errFlags[b] && !(hostWrEn && hostAddr == ADDR_W'(1) && hostWdata[b]) |=> errFlags[b]); // R6
  end
endmodule

bind fifo_host_access fha_checker i_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostAddr(hostAddr), .hostWdata(hostWdata), .smTxPop(smTxPop), .smRxPush(smRxPush),
  .txFull(txFull), .txEmpty(txEmpty), .rxEmpty(rxEmpty),
  .txLevel(txLevel), .rxLevel(rxLevel), .errFlags(errFlags)
);

// File: tb/test_fifo_host_access.sv
module test_fifo_host_access;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [4:0] hostAddr = '0;
  logic [31:0] hostWdata = '0, hostRdata;
  logic [3:0] smTxPop = '0, smRxPush = '0;
  logic [127:0] smTxData, smRxData = '0;

  int nChecks = 0, nErrors = 0;
  logic [31:0] txM [4][4];
  logic [31:0] rxM [4][4];
  int txN [4];
  int rxN [4];
  logic [7:0] mFlags;
  logic [31:0] sampled;
  bit done = 0;

  always #2 clk = ~clk;

  fifo_host_access i_fifo_host_access (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .smTxPop(smTxPop), .smTxData(smTxData), .smRxPush(smRxPush), .smRxData(smRxData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    for (int m = 0; m < 4; m++) begin
      s[m] = (txN[m] == 4); s[4+m] = (txN[m] == 0);
      s[8+m] = (rxN[m] == 4); s[12+m] = (rxN[m] == 0);
    end
    return s;
  endfunction

  function automatic logic [31:0] expLevel();
    logic [31:0] l = '0;
    for (int m = 0; m < 4; m++) begin
      l[8*m +: 4] = 4'(txN[m]);
      l[8*m+4 +: 4] = 4'(rxN[m]);
    end
    return l;
  endfunction

  task automatic cyc(input logic we, input logic re, input logic [4:0] a, input logic [31:0] d,
                     input logic [3:0] tp, input logic [3:0] rp, input logic [127:0] rd);
    int preTx [4];
    int preRx [4];
    @(negedge clk);
    hostWrEn = we; hostRdEn = re; hostAddr = a; hostWdata = d;
    smTxPop = tp; smRxPush = rp; smRxData = rd;
    #1;
    sampled = hostRdata;
    for (int m = 0; m < 4; m++) begin preTx[m] = txN[m]; preRx[m] = rxN[m]; end
    if (re && a == 5'd0) check(hostRdata == expStatus(), "R7 status", hostRdata, expStatus());
    if (re && a == 5'd1) check(hostRdata == {24'b0, mFlags}, "R6 flags", hostRdata, {24'b0, mFlags});
    if (re && a == 5'd2) check(hostRdata == expLevel(), "R8 R9 level", hostRdata, expLevel());
    for (int m = 0; m < 4; m++) begin
      if (tp[m] && preTx[m] > 0) begin
        check(smTxData[32*m +: 32] == txM[m][0], "R1 R12 engine tx order", smTxData[32*m +: 32], txM[m][0]);
        for (int k = 0; k < 3; k++) txM[m][k] = txM[m][k+1];
        txN[m]--;
      end
      if (re && a == 5'(8 + m)) begin
        if (preRx[m] > 0) begin
          check(hostRdata == rxM[m][0], "R3 R5 host rx order", hostRdata, rxM[m][0]);
          for (int k = 0; k < 3; k++) rxM[m][k] = rxM[m][k+1];
          rxN[m]--;
        end else mFlags[4+m] = 1'b1;
      end
    end
    for (int m = 0; m < 4; m++) begin
      if (we && a == 5'(4 + m)) begin
        if (preTx[m] < 4) begin txM[m][txN[m]] = d; txN[m]++; end
        else mFlags[m] = 1'b1;
      end
      if (rp[m] && preRx[m] < 4) begin rxM[m][rxN[m]] = rd[32*m +: 32]; rxN[m]++; end
    end
    if (we && a == 5'd1) mFlags = mFlags & ~d[7:0];
    @(posedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d, 4'b0, 4'b0, '0);
  endtask

  task automatic rd(input logic [4:0] a);
    cyc(1'b0, 1'b1, a, '0, 4'b0, 4'b0, '0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int m = 0; m < 4; m++) begin txN[m] = 0; rxN[m] = 0; end
    mFlags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R13: reset state
    rd(5'd0); check(sampled == 32'h0000_F0F0, "R13 reset status", sampled, 32'h0000_F0F0);
    rd(5'd2); check(sampled == 32'h0, "R13 reset level", sampled, 32'h0);
    rd(5'd1); check(sampled == 32'h0, "R13 reset flags", sampled, 32'h0);

    // R1, R2: fill transmit queue 0 and overflow it
    for (int i = 0; i < 4; i++) wr(5'd4, 32'hA000_0000 + i);
    rd(5'd2); check(sampled == 32'h4, "R1 R8 level after four pushes", sampled, 32'h4);
    wr(5'd4, 32'hDEAD_BEEF);
    rd(5'd2); check(sampled == 32'h4, "R2 level unchanged on overflow", sampled, 32'h4);
    rd(5'd1); check(sampled == 32'h1, "R2 overflow flag", sampled, 32'h1);
    rd(5'd0);

    // R4: underflow on receive 2
    rd(5'd10);
    rd(5'd1); check(sampled == 32'h41, "R4 underflow flag bit 6", sampled, 32'h41);
    rd(5'd2); check(sampled == 32'h4, "R4 level unchanged on underflow", sampled, 32'h4);

    // R6: zero write keeps flags, one-bit write clears only that bit
    wr(5'd1, 32'h0);
    rd(5'd1); check(sampled == 32'h41, "R6 zero write keeps flags", sampled, 32'h41);
    wr(5'd1, 32'h40);
    rd(5'd1); check(sampled == 32'h1, "R6 single bit clear", sampled, 32'h1);
    wr(5'd1, 32'hFF);

    // R9: simultaneous push and pop on transmit 0 at level 3
    cyc(1'b0, 1'b0, 5'd0, '0, 4'b0001, 4'b0, '0);
    cyc(1'b1, 1'b0, 5'd4, 32'hB00B_0001, 4'b0001, 4'b0, '0);
    rd(5'd2); check(sampled == 32'h3, "R9 level stays at three", sampled, 32'h3);

    // R12: engine pop on empty transmit 1, engine push into full receive 1
    cyc(1'b0, 1'b0, 5'd0, '0, 4'b0010, 4'b0, '0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 5'd0, '0, 4'b0, 4'b0010, {64'h0, 32'hC000_0000 + i, 32'h0});
    rd(5'd2); check(sampled[15:8] == 8'h40, "R12 ignored engine strobes", {24'h0, sampled[15:8]}, 32'h40);
    for (int i = 0; i < 4; i++) rd(5'd9);

    // random mix against the queue model
    for (int it = 0; it < 4000; it++) begin
      int r;
      logic [3:0] m;
      logic [127:0] rdat;
      r = $urandom % 11;
      m = 4'($urandom % 4);
      rdat = {$urandom, $urandom, $urandom, $urandom};
      case (r)
        0, 1, 2: cyc(1'b1, 1'b0, 5'd4 + 5'(m), $urandom, 4'($urandom), 4'($urandom), rdat);
        3, 4, 5: cyc(1'b0, 1'b1, 5'd8 + 5'(m), '0, 4'($urandom), 4'($urandom), rdat);
        6: cyc(1'b0, 1'b1, 5'd0, '0, 4'($urandom), 4'($urandom), rdat);
        7: cyc(1'b0, 1'b1, 5'd2, '0, 4'($urandom), 4'($urandom), rdat);
        8: cyc(1'b0, 1'b1, 5'd1, '0, 4'($urandom), 4'($urandom), rdat);
        9: cyc(1'b1, 1'b0, 5'd1, $urandom, 4'($urandom), 4'($urandom), rdat);
        default: cyc(1'b0, 1'b0, 5'd0, '0, 4'($urandom), 4'($urandom), rdat);
      endcase
    end
    rd(5'd0); rd(5'd1); rd(5'd2);

    // R10, R11: indexed receive access on engine 3 (slots at 28..31)
    wr(5'd3, 32'h40);
    for (int i = 0; i < 4; i++) wr(5'(28 + i), 32'h5100_0000 + i);
    for (int i = 0; i < 4; i++) begin
      rd(5'(28 + i));
      check(sampled == 32'h5100_0000 + i, "R10 indexed readback enable A", sampled, 32'h5100_0000 + i);
    end
    wr(5'd3, 32'hC0);
    rd(5'd29); check(sampled == 32'h0, "R11 both enables read zero", sampled, 32'h0);
    wr(5'd29, 32'hBAD0_BAD0);
    wr(5'd3, 32'h80);
    rd(5'd29); check(sampled == 32'h5100_0001, "R10 R11 enable B and ignored write", sampled, 32'h5100_0001);
    wr(5'd3, 32'h0);
    wr(5'd30, 32'hBAD1_BAD1);
    rd(5'd30); check(sampled == 32'h0, "R11 no enable reads zero", sampled, 32'h0);
    wr(5'd3, 32'h40);
    rd(5'd30); check(sampled == 32'h5100_0002, "R11 write without enable ignored", sampled, 32'h5100_0002);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule